// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, frame clock, data line) and turns it into parallel left and right words in the master clock domain. All three link lines are resynchronised into the master clock, which runs at 256 times the sample rate. The block finds the edges of the bit clock and the frame clock there, so no flop is clocked by a serial clock.

A 3-bit format code selects one of three justifications: I2S, MSB-justified or LSB-justified. It also selects a word length of 16 or 18 bits. The data line is sampled at each bit-clock rise. The collected word moves to the left or right output register when the frame clock changes level. Which edge feeds which channel depends on the justification. A one-cycle strobe marks each completed stereo pair.

Top module: `pcm_serial_rx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With justification code `fmt_code[1:0]` = 00 (I2S), the word's MSB is the data bit sampled at the second bit-clock rise after a frame-clock change. A rising frame-clock edge loads `left_o`, and a falling edge loads `right_o`.
- R3: With `fmt_code[1:0]` = 01 (MSB-justified), the MSB is the bit sampled at the first bit-clock rise after a frame-clock change. A falling frame-clock edge loads `left_o`, and a rising edge loads `right_o`.
- R4: With `fmt_code[1:0]` = 10 (LSB-justified), the word is formed from the last 16 or 18 bits sampled before a frame-clock change, with the last bit as the LSB. The edge-to-channel mapping is the one in R3.
- R5: `fmt_code[2]` = 1 selects 18-bit words, and 0 selects 16-bit words. A 16-bit word is presented in bits [17:2] of the output, and bits [1:0] are zero.
- R6: In the I2S and MSB-justified modes, bits of a half-frame that follow the word have no effect on the output.
- R7: Codes 011 and 111 behave exactly like code 000 (I2S, 16-bit).
- R8: `valid_o` is high for exactly one master-clock cycle each time `right_o` is loaded. Between frame-clock edges, `left_o` and `right_o` hold their values.
- R9: Each bit clock period is at least two master clock cycles. Every bit of a half-frame is captured at that minimum period as well as at slower ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_code | input | 3 | Format code: bit 2 is the word length, bits 1:0 are the justification |
| bclk_i | input | 1 | Serial bit clock, asynchronous to `clk` in phase |
| lrclk_i | input | 1 | Serial frame clock, marks the channel |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 18 | Last left-channel word, left-aligned |
| right_o | output | 18 | Last right-channel word, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a stereo pair completes |

## Verification
The hardest situation to reach is the one where the word window meets the edge of the half-frame. Examples are an I2S half-frame only one bit longer than the word, a justified half-frame exactly as long as the word, and the bit clock running at its two-cycle minimum. In these cases a single misplaced bit position or a dropped edge corrupts a word. The bench sends random half-frame lengths and bit-clock speeds for every format code, using a fixed seed. Each format group then ends with directed frames at the minimum legal half-frame length and the fastest bit clock. All expected words are derived from the transmitted bit stream.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic [1:0] {
      JUST_I2S = 2'b00,
      JUST_MSB = 2'b01,
      JUST_LSB = 2'b10
   } just_e;

   typedef struct packed {
      just_e just;
      logic  long_word;
   } fmt_t;

   // Unused justification code 11 falls back to the I2S 16-bit format.
   function automatic fmt_t decode_fmt(input logic [2:0] code);
      fmt_t f;
      if (code[1:0] == 2'b11) begin
         f.just      = JUST_I2S;
         f.long_word = 1'b0;
      end else begin
         f.just      = just_e'(code[1:0]);
         f.long_word = code[2];
      end
      return f;
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int N_LINES = 3,
   parameter int STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] async_i,
   output logic [N_LINES-1:0] level_o,
   output logic [N_LINES-1:0] rise_o,
   output logic [N_LINES-1:0] fall_o
);

   generate
      if (STAGES < 2) begin : bad_stages
         $error("pcm_rx_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < N_LINES; g++) begin : line
         // pipe[STAGES-1] is the synchronised level; pipe[STAGES] is its previous value
         logic [STAGES:0] pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-1:0], async_i[g]};
         end
         assign level_o[g] = pipe[STAGES-1];
         assign rise_o[g]  =  pipe[STAGES-1] & ~pipe[STAGES];
         assign fall_o[g]  = ~pipe[STAGES-1] &  pipe[STAGES];
      end
   endgenerate

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
   import pcm_rx_pkg::*;
#(
   parameter int LONG_W  = 18,
   parameter int SHORT_W = 16,
   parameter int CNT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_t              fmt,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              frame_stb,
   output logic [LONG_W-1:0] word_o
);

   localparam int                 PAD_W   = LONG_W - SHORT_W;
   localparam logic [CNT_W-1:0]   POS_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0]   LEN_L   = CNT_W'(LONG_W);
   localparam logic [CNT_W-1:0]   LEN_S   = CNT_W'(SHORT_W);

   generate
      if (2 ** CNT_W - 1 < LONG_W + 1) begin : bad_cnt
         $error("pcm_rx_shifter: CNT_W too small for LONG_W");
      end
   endgenerate

   logic [LONG_W-1:0] sr;
   logic [CNT_W-1:0]  pos;
   logic [CNT_W-1:0]  first;
   logic [CNT_W-1:0]  last_x;
   logic              in_win;

   // Window of bit positions to keep: starts at 0 (MSB-justified) or 1 (I2S).
   // LSB-justified keeps shifting and lets the oldest bits fall out.
   always_comb begin
      first  = (fmt.just == JUST_I2S) ? CNT_W'(1) : '0;
      last_x = first + (fmt.long_word ? LEN_L : LEN_S);
      in_win = (fmt.just == JUST_LSB) || ((pos >= first) && (pos < last_x));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || frame_stb) begin
         sr  <= '0;
         pos <= '0;
      end else if (bit_stb) begin
         if (pos != POS_MAX) pos <= pos + 1'b1;
         if (in_win)         sr  <= {sr[LONG_W-2:0], bit_val};
      end
   end

   assign word_o = fmt.long_word ? sr : {sr[SHORT_W-1:0], {PAD_W{1'b0}}};

   // R6
   pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pos) == POS_MAX && !$past(frame_stb)) |-> pos == POS_MAX);

   // R6
   window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !frame_stb && !in_win && fmt.just != JUST_LSB) |=> $stable(sr));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_rx_pkg::*;
#(
   parameter int LONG_W      = 18,
   parameter int SHORT_W     = 16,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        fmt_code,
   input  logic              bclk_i,
   input  logic              lrclk_i,
   input  logic              sdata_i,
   output logic [LONG_W-1:0] left_o,
   output logic [LONG_W-1:0] right_o,
   output logic              valid_o
);

   localparam int PAD_W  = LONG_W - SHORT_W;
   localparam int LN_BCK = 0;
   localparam int LN_LR  = 1;
   localparam int LN_DAT = 2;

   generate
      if (SHORT_W >= LONG_W) begin : bad_widths
         $error("pcm_serial_rx: SHORT_W must be below LONG_W");
      end
   endgenerate

   fmt_t       fmt;
   logic [2:0] lvl, rise, fall;
   logic       bit_stb, lr_rise, lr_fall, frame_stb;
   logic       to_left, to_right;
   logic [LONG_W-1:0] word;

   assign fmt = decode_fmt(fmt_code);

   pcm_rx_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sdata_i, lrclk_i, bclk_i}),
      .level_o (lvl),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   assign bit_stb   = rise[LN_BCK];
   assign lr_rise   = rise[LN_LR];
   assign lr_fall   = fall[LN_LR];
   assign frame_stb = lr_rise | lr_fall;

   pcm_rx_shifter #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt       (fmt),
      .bit_stb   (bit_stb),
      .bit_val   (lvl[LN_DAT]),
      .frame_stb (frame_stb),
      .word_o    (word)
   );

   // I2S carries left while the frame clock is low; justified modes while high.
   always_comb begin
      if (fmt.just == JUST_I2S) begin
         to_left  = lr_rise;
         to_right = lr_fall;
      end else begin
         to_left  = lr_fall;
         to_right = lr_rise;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= to_right;
         if (to_left)  left_o  <= word;
         if (to_right) right_o <= word;
      end
   end

   // R8
   right_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(right_o) |-> valid_o);

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R2
   left_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(left_o) |-> $past(frame_stb));

   // R5
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(fmt.long_word)) |-> right_o[PAD_W-1:0] == '0);

endmodule

// File: tb/sim_pcm_serial_rx.sv
module sim_pcm_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  fmt_code;
   logic        bclk, lrclk, sdata;
   logic [17:0] left_o, right_o;
   logic        valid_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [17:0] exp_l [0:255];
   logic [17:0] exp_r [0:255];
   bit          exp_ck[0:255];
   string       exp_tg[0:255];
   int          wr_p = 0;
   int          rd_p = 0;

   always #4 clk = ~clk;

   pcm_serial_rx u0 (
      .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code),
      .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   task automatic check18(input string tag, input logic [17:0] got, input logic [17:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Expected word from the transmitted half-frame: bits[n-1] is sent first.
   function automatic logic [17:0] exp_word(input logic [2:0] code, input logic [63:0] bits, input int n);
      int   just = (code[1:0] == 2'b11) ? 0 : int'(code[1:0]);
      bit   lng  = (code[1:0] == 2'b11) ? 1'b0 : code[2];
      int   len  = lng ? 18 : 16;
      int   off  = (just == 0) ? 1 : 0;
      logic [17:0] w = '0;
      for (int j = 0; j < len; j++) begin
         if (just == 2) w[len-1-j] = bits[len-1-j];
         else           w[len-1-j] = bits[n-1-off-j];
      end
      return lng ? w : {w[15:0], 2'b00};
   endfunction

   function automatic bit is_i2s(input logic [2:0] code);
      return (code[1:0] == 2'b00) || (code[1:0] == 2'b11);
   endfunction

   task automatic put_bit(input logic d, input logic lr, input int hp);
      @(negedge clk);
      bclk  = 1'b0;
      sdata = d;
      lrclk = lr;
      repeat (hp) @(negedge clk);
      bclk = 1'b1;
      repeat (hp - 1) @(negedge clk);
   endtask

   task automatic send_frame(input logic [2:0] code, input int n, input int hp, input string tag);
      logic [63:0] lb = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      logic lv = is_i2s(code) ? 1'b0 : 1'b1;
      exp_l[wr_p]  = exp_word(code, lb, n);
      exp_r[wr_p]  = exp_word(code, rb, n);
      exp_ck[wr_p] = 1'b1;
      exp_tg[wr_p] = tag;
      wr_p++;
      for (int i = n - 1; i >= 0; i--) put_bit(lb[i], lv, hp);
      for (int i = n - 1; i >= 0; i--) put_bit(rb[i], ~lv, hp);
   endtask

   // Monitor: each strobe is matched to the next expected stereo pair (R8).
   always @(negedge clk) begin
      if (rst_n === 1'b1 && valid_o === 1'b1) begin
         if (rd_p >= wr_p) begin
            checks++; fails++;
            $display("FAIL R8: unexpected valid, got 1 expected 0");
         end else begin
            if (exp_ck[rd_p]) begin
               check18({exp_tg[rd_p], " left"},  left_o,  exp_l[rd_p]);
               check18({exp_tg[rd_p], " right"}, right_o, exp_r[rd_p]);
            end
            rd_p++;
         end
      end
   end

   task automatic run_group(input logic [2:0] code, input string tag);
      int   len  = (code[1:0] != 2'b11 && code[2]) ? 18 : 16;
      int   nmin = is_i2s(code) ? len + 1 : len;
      logic lv   = is_i2s(code) ? 1'b0 : 1'b1;
      logic [17:0] hl, hr;
      @(negedge clk);
      rst_n = 1'b0; fmt_code = code; bclk = 0; lrclk = 0; sdata = 0;
      repeat (4) @(negedge clk);
      // R1
      check18("R1 left reset", left_o, '0);
      check18("R1 right reset", right_o, '0);
      check18("R1 valid reset", {17'd0, valid_o}, '0);
      wr_p = 0; rd_p = 0;
      rst_n = 1'b1;
      if (!is_i2s(code)) begin
         exp_ck[wr_p] = 1'b0; exp_tg[wr_p] = tag; wr_p++;
      end
      for (int f = 0; f < 5; f++) begin
         int pick = int'($urandom_range(0, 2));
         int n    = (pick == 0) ? 20 : (pick == 1) ? 24 : 32;
         int hp   = int'($urandom_range(1, 2));
         send_frame(code, n, hp, tag);
      end
      // R9 directed: shortest legal half-frame at the fastest bit clock
      send_frame(code, nmin, 1, {tag, " R9"});
      send_frame(code, nmin, 2, {tag, " R9"});
      // R6 directed: long half-frame, trailing bits must be ignored
      send_frame(code, 32, 1, {tag, " R6"});
      // closing frame-clock edge, then bits with no further edge
      put_bit(1'b0, lv, 1);
      repeat (8) @(negedge clk);
      hl = left_o; hr = right_o;
      for (int i = 0; i < 10; i++) put_bit(i[0], lv, 1);
      repeat (6) @(negedge clk);
      // R8
      check18("R8 left hold", left_o, hl);
      check18("R8 right hold", right_o, hr);
      checks++;
      if (rd_p != wr_p) begin
         fails++;
         $display("FAIL R8: strobes got %0d expected %0d", rd_p, wr_p);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; fmt_code = 3'b000; bclk = 0; lrclk = 0; sdata = 0;
      run_group(3'b000, "R2 i2s16");
      run_group(3'b100, "R2 R5 i2s18");
      run_group(3'b001, "R3 msb16");
      run_group(3'b101, "R3 R5 msb18");
      run_group(3'b010, "R4 lsb16");
      run_group(3'b110, "R4 R5 lsb18");
      run_group(3'b011, "R7 code011");
      run_group(3'b111, "R7 code111");
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule